// File: doc/BRIEF.md
# Power Mode Sequencer

The sequencer steps a system-on-chip through five power modes: full-rate running, half-rate running, bus-parked idle, light sleep and deep sleep. Software selects a mode by writing a 3-bit command. Interrupts, DMA requests and wake-up events move the block out of its parked and sleeping modes on their own. The outputs drive the CPU clock selector, the CPU and system clock gates, the main oscillator and PLL enables, the SDRAM self-refresh request and a bus-ownership request. The current mode can be read back at all times.

Light sleep and deep sleep are reached only from idle, and only while the bus arbiter grants the bus to this block and the auxiliary (video and communication) clocks are already off. This guarantees that no memory access is cut short. In deep sleep the oscillator and PLL are switched off. The controller then acts only on a low-speed tick, which is derived by dividing its clock by `LP_DIV`. When a wake-up arrives in deep sleep, the oscillator and PLL are enabled, and the controller waits a programmable number of ticks for lock before it reopens the bus path through idle.

Top module: `pmode_ctrl`

## Requirements
- R1: After reset the mode readback is 0 (full rate). `cpu_half` is 0, `cpu_clk_en` and `sys_clk_en` are 1, `osc_en` and `pll_en` are 1, and `sdram_sr_req` and `bus_req` are 0.
- R2: Command codes are full rate = 0, half rate = 1, idle = 2, sleep = 3 and deep sleep = 4. Code 1 moves the block from full rate to half rate, and code 0 moves it back. `cpu_half` is 1 in half rate and 0 in full rate.
- R3: Code 2, written in full rate or half rate, enters idle (readback 2) on the next cycle. In idle, `bus_req` is 1 and `cpu_clk_en` is 0.
- R4: In idle, any of `irq_fast`, `irq_norm` or `dma_req` leaves idle on the next cycle and drops `bus_req`. The block returns to full rate if idle was entered from full rate, and otherwise to half rate.
- R5: Code 3, written in idle while `bus_grant` is 1 and `aux_clk_on` is 0, enters sleep (readback 3). In sleep, `sdram_sr_req` is 1, `sys_clk_en` is 0, and the oscillator and PLL stay on.
- R6: A sleep or deep-sleep command is ignored and the mode is held in these cases: the block is outside idle, `bus_grant` is 0, or `aux_clk_on` is 1.
- R7: If a release source and a sleep command arrive in the same idle cycle, the release wins.
- R8: Code 4, accepted under the R5 conditions, enters deep sleep (readback 4). In deep sleep, `osc_en` and `pll_en` are 0 and `sdram_sr_req` is 1.
- R9: In sleep, any of `wake_key`, `wake_rtc` or `wake_ring` enters idle on the next cycle. A later release from that idle goes to half rate.
- R10: In deep sleep, wake-up is sampled only on the low-speed tick. The tick falls every `LP_DIV` cycles, and the first one comes at the `LP_DIV`-th edge after entry. On that tick `osc_en` and `pll_en` return to 1 while the readback stays 4.
- R11: After a deep-sleep wake-up, the block waits `max(lock_cnt,1)` ticks and then enters idle. A later release from that idle goes to half rate.
- R12: Codes 5 to 7 are ignored in every mode. Codes 0 and 1 are ignored in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Mode command write strobe |
| cmd_mode | input | 3 | Mode command code |
| irq_fast | input | 1 | Fast CPU interrupt |
| irq_norm | input | 1 | Normal CPU interrupt |
| dma_req | input | 1 | DMA bus request |
| bus_grant | input | 1 | Arbiter grants the bus to this block |
| aux_clk_on | input | 1 | Video or communication clock still enabled |
| wake_key | input | 1 | On-key wake-up event |
| wake_rtc | input | 1 | RTC alarm wake-up event |
| wake_ring | input | 1 | Modem ring wake-up event |
| lock_cnt | input | LOCK_W | PLL lock wait in low-speed ticks |
| mode_o | output | 3 | Current mode readback |
| cpu_half | output | 1 | CPU clock select, 1 = half rate |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | Internal system clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| sdram_sr_req | output | 1 | SDRAM self-refresh request |
| bus_req | output | 1 | Bus ownership request |

## Verification
Two functions can act on the same idle cycle: leaving idle on an interrupt, and accepting a sleep command. The bench writes code 3 with the grant held and `irq_norm` raised in the same cycle. It then requires half rate, with self-refresh low, on the next cycle. A similar overlap can occur in deep sleep, where wake-up and the low-speed tick meet. There the bench holds the wake-up level high and checks that the enables stay off until exactly the tick edge, then come on at that edge.

// File: rtl/pmode_ctrl.sv
module pmode_ctrl #(
  parameter int LP_DIV = 8,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_mode,
  input  logic              irq_fast,
  input  logic              irq_norm,
  input  logic              dma_req,
  input  logic              bus_grant,
  input  logic              aux_clk_on,
  input  logic              wake_key,
  input  logic              wake_rtc,
  input  logic              wake_ring,
  input  logic [LOCK_W-1:0] lock_cnt,
  output logic [2:0]        mode_o,
  output logic              cpu_half,
  output logic              cpu_clk_en,
  output logic              sys_clk_en,
  output logic              osc_en,
  output logic              pll_en,
  output logic              sdram_sr_req,
  output logic              bus_req
);

  localparam int DIV_W = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LP_DIV - 1);
  localparam logic [2:0] C_RUN = 3'd0, C_SLOW = 3'd1, C_IDLE = 3'd2,
                         C_SLEEP = 3'd3, C_DEEP = 3'd4;

  typedef enum logic [2:0] {
    S_RUN = 3'd0, S_SLOW = 3'd1, S_IDLE = 3'd2,
    S_SLEEP = 3'd3, S_DEEP = 3'd4, S_LOCK = 3'd5
  } st_t;

  st_t st, st_n;
  logic ret_fast, ret_fast_n;
  logic [DIV_W-1:0] div_q;
  logic [LOCK_W-1:0] lk_q;
  logic [LOCK_W:0] lk_inc;

  wire lp_active   = (st == S_DEEP) || (st == S_LOCK);
  wire lp_tick     = lp_active && (div_q == DIV_LAST);
  wire wake        = wake_key | wake_rtc | wake_ring;
  wire release_bus = irq_fast | irq_norm | dma_req;
  wire park_ok     = bus_grant && !aux_clk_on;

  assign lk_inc = {1'b0, lk_q} + 1'b1;

  always_comb begin
    st_n = st;
    ret_fast_n = ret_fast;
    case (st)
      S_RUN:
        if (cmd_wr) begin
          if (cmd_mode == C_SLOW) st_n = S_SLOW;
          else if (cmd_mode == C_IDLE) begin
            st_n = S_IDLE;
            ret_fast_n = 1'b1;
          end
        end
      S_SLOW:
        if (cmd_wr) begin
          if (cmd_mode == C_RUN) st_n = S_RUN;
          else if (cmd_mode == C_IDLE) begin
            st_n = S_IDLE;
            ret_fast_n = 1'b0;
          end
        end
      S_IDLE:
        if (release_bus) st_n = ret_fast ? S_RUN : S_SLOW;
        else if (cmd_wr && park_ok) begin
          if (cmd_mode == C_SLEEP) st_n = S_SLEEP;
          else if (cmd_mode == C_DEEP) st_n = S_DEEP;
        end
      S_SLEEP:
        if (wake) begin
          st_n = S_IDLE;
          ret_fast_n = 1'b0;
        end
      S_DEEP:
        if (lp_tick && wake) begin
          st_n = S_LOCK;
          ret_fast_n = 1'b0;
        end
      S_LOCK:
        if (lp_tick && (lk_inc >= {1'b0, lock_cnt})) st_n = S_IDLE;
      default: st_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      ret_fast <= 1'b1;
      div_q    <= '0;
      lk_q     <= '0;
    end else begin
      st       <= st_n;
      ret_fast <= ret_fast_n;
      if (!lp_active || lp_tick) div_q <= '0;
      else div_q <= div_q + 1'b1;
      if (st != S_LOCK) lk_q <= '0;
      else if (lp_tick) lk_q <= lk_inc[LOCK_W-1:0];
    end
  end

  assign mode_o       = (st == S_LOCK) ? C_DEEP : st;
  assign cpu_half     = !((st == S_RUN) || ((st == S_IDLE) && ret_fast));
  assign cpu_clk_en   = (st == S_RUN) || (st == S_SLOW);
  assign sys_clk_en   = (st == S_RUN) || (st == S_SLOW) || (st == S_IDLE);
  assign osc_en       = (st != S_DEEP);
  assign pll_en       = (st != S_DEEP);
  assign sdram_sr_req = (st == S_SLEEP) || lp_active;
  assign bus_req      = (st == S_IDLE) || sdram_sr_req;

endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_fast,
  input logic       irq_norm,
  input logic       dma_req,
  input logic       bus_grant,
  input logic       wake_key,
  input logic       wake_rtc,
  input logic       wake_ring,
  input logic [2:0] mode_o,
  input logic       osc_en,
  input logic       pll_en,
  input logic       sdram_sr_req,
  input logic       bus_req
);

  assert_sr_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdram_sr_req) |-> ($past(mode_o) == 3'd2) && $past(bus_grant));

  assert_osc_off_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(mode_o) == 3'd2) && $past(bus_grant));

  assert_release_drops_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd2) && (irq_fast || irq_norm || dma_req)) |=> !bus_req);

  assert_no_direct_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o <= 3'd1) |=> (mode_o <= 3'd2));

  assert_pll_restart_on_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(wake_key || wake_rtc || wake_ring));

  assert_sleep_wake_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd3) && (wake_key || wake_rtc || wake_ring)) |=> (mode_o == 3'd2));

endmodule

bind pmode_ctrl pmode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_fast(irq_fast), .irq_norm(irq_norm),
  .dma_req(dma_req), .bus_grant(bus_grant), .wake_key(wake_key),
  .wake_rtc(wake_rtc), .wake_ring(wake_ring), .mode_o(mode_o),
  .osc_en(osc_en), .pll_en(pll_en), .sdram_sr_req(sdram_sr_req),
  .bus_req(bus_req)
);

// File: tb/pmode_ctrl_tb_top.sv
module pmode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LP_DIV = 8;
  localparam int LOCK_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, irq_fast = 0, irq_norm = 0, dma_req = 0;
  logic bus_grant = 0, aux_clk_on = 0, wake_key = 0, wake_rtc = 0, wake_ring = 0;
  logic [2:0] cmd_mode = 0;
  logic [LOCK_W-1:0] lock_cnt = 8'd3;
  logic [2:0] mode_o;
  logic cpu_half, cpu_clk_en, sys_clk_en, osc_en, pll_en, sdram_sr_req, bus_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmode_ctrl #(.LP_DIV(LP_DIV), .LOCK_W(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .irq_fast(irq_fast), .irq_norm(irq_norm), .dma_req(dma_req),
    .bus_grant(bus_grant), .aux_clk_on(aux_clk_on), .wake_key(wake_key),
    .wake_rtc(wake_rtc), .wake_ring(wake_ring), .lock_cnt(lock_cnt),
    .mode_o(mode_o), .cpu_half(cpu_half), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .osc_en(osc_en), .pll_en(pll_en),
    .sdram_sr_req(sdram_sr_req), .bus_req(bus_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, applied at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic w, input logic [2:0] code, input logic fi,
                     input logic ni, input logic dm, input logic wk);
    cmd_wr = w; cmd_mode = code; irq_fast = fi; irq_norm = ni; dma_req = dm; wake_key = wk;
    @(negedge clk);
    cmd_wr = 0; irq_fast = 0; irq_norm = 0; dma_req = 0; wake_key = 0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "mode", mode_o, 0);
    chk("R1", "cpu_half", cpu_half, 0);
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "sys_clk_en", sys_clk_en, 1);
    chk("R1", "osc/pll", {osc_en, pll_en}, 3);
    chk("R1", "sr/bus", {sdram_sr_req, bus_req}, 0);
  endtask

  task automatic t_run_slow;
    cyc(1, 3'd1, 0, 0, 0, 0);
    chk("R2", "mode after code 1", mode_o, 1);
    chk("R2", "cpu_half slow", cpu_half, 1);
    cyc(1, 3'd0, 0, 0, 0, 0);
    chk("R2", "mode after code 0", mode_o, 0);
    chk("R2", "cpu_half run", cpu_half, 0);
  endtask

  task automatic t_idle_from_run;
    cyc(1, 3'd2, 0, 0, 0, 0);
    chk("R3", "mode idle", mode_o, 2);
    chk("R3", "bus_req idle", bus_req, 1);
    chk("R3", "cpu_clk_en idle", cpu_clk_en, 0);
    cyc(1, 3'd0, 0, 0, 0, 0);
    chk("R12", "code 0 in idle", mode_o, 2);
    cyc(1, 3'd1, 0, 0, 0, 0);
    chk("R12", "code 1 in idle", mode_o, 2);
    cyc(0, 3'd0, 1, 0, 0, 0);
    chk("R4", "irq_fast return to run", mode_o, 0);
    chk("R4", "bus_req released", bus_req, 0);
  endtask

  task automatic t_idle_from_slow;
    cyc(1, 3'd1, 0, 0, 0, 0);
    cyc(1, 3'd2, 0, 0, 0, 0);
    chk("R3", "mode idle from slow", mode_o, 2);
    cyc(0, 3'd0, 0, 0, 1, 0);
    chk("R4", "dma return to slow", mode_o, 1);
    chk("R4", "bus_req released dma", bus_req, 0);
  endtask

  task automatic t_ignore;
    bus_grant = 1;
    cyc(1, 3'd3, 0, 0, 0, 0);
    chk("R6", "sleep from slow ignored", mode_o, 1);
    chk("R6", "no self-refresh", sdram_sr_req, 0);
    cyc(1, 3'd4, 0, 0, 0, 0);
    chk("R6", "deep from slow ignored", mode_o, 1);
    cyc(1, 3'd7, 0, 0, 0, 0);
    chk("R12", "code 7 ignored", mode_o, 1);
    cyc(1, 3'd5, 0, 0, 0, 0);
    chk("R12", "code 5 ignored", mode_o, 1);
    cyc(1, 3'd2, 0, 0, 0, 0);
    bus_grant = 0;
    cyc(1, 3'd3, 0, 0, 0, 0);
    chk("R6", "sleep without grant", mode_o, 2);
    bus_grant = 1; aux_clk_on = 1;
    cyc(1, 3'd4, 0, 0, 0, 0);
    chk("R6", "deep with aux clocks on", mode_o, 2);
    chk("R6", "osc stays on", osc_en, 1);
    aux_clk_on = 0;
    cyc(1, 3'd6, 0, 0, 0, 0);
    chk("R12", "code 6 in idle", mode_o, 2);
    cyc(0, 3'd0, 0, 1, 0, 0);
    chk("R4", "irq_norm return to slow", mode_o, 1);
  endtask

  task automatic t_collision;
    bus_grant = 1;
    cyc(1, 3'd2, 0, 0, 0, 0);
    cyc(1, 3'd3, 0, 1, 0, 0);
    chk("R7", "release beats sleep", mode_o, 1);
    chk("R7", "no self-refresh", sdram_sr_req, 0);
  endtask

  task automatic t_sleep;
    bus_grant = 1;
    cyc(1, 3'd0, 0, 0, 0, 0);
    cyc(1, 3'd2, 0, 0, 0, 0);
    cyc(1, 3'd3, 0, 0, 0, 0);
    chk("R5", "mode sleep", mode_o, 3);
    chk("R5", "self-refresh", sdram_sr_req, 1);
    chk("R5", "sys clock gated", sys_clk_en, 0);
    chk("R5", "osc/pll on", {osc_en, pll_en}, 3);
    cyc(0, 3'd0, 0, 0, 0, 0);
    chk("R5", "sleep held", mode_o, 3);
    cyc(0, 3'd0, 0, 0, 0, 1);
    chk("R9", "wake to idle", mode_o, 2);
    chk("R9", "self-refresh off", sdram_sr_req, 0);
    cyc(0, 3'd0, 1, 0, 0, 0);
    chk("R9", "release to slow", mode_o, 1);
  endtask

  task automatic t_deep;
    bus_grant = 1;
    cyc(1, 3'd2, 0, 0, 0, 0);
    cyc(1, 3'd4, 0, 0, 0, 0);
    chk("R8", "mode deep", mode_o, 4);
    chk("R8", "osc/pll off", {osc_en, pll_en}, 0);
    chk("R8", "self-refresh", sdram_sr_req, 1);
    wake_rtc = 1;
    for (int i = 1; i < LP_DIV; i++) @(negedge clk);
    #1;
    chk("R10", "pll off before tick", pll_en, 0);
    @(negedge clk); #1;
    chk("R10", "pll on at tick", pll_en, 1);
    chk("R10", "osc on at tick", osc_en, 1);
    chk("R10", "readback during lock", mode_o, 4);
    wake_rtc = 0;
    for (int i = 1; i < 3 * LP_DIV; i++) @(negedge clk);
    #1;
    chk("R11", "still locking", mode_o, 4);
    @(negedge clk); #1;
    chk("R11", "lock done to idle", mode_o, 2);
    chk("R11", "self-refresh off", sdram_sr_req, 0);
    cyc(0, 3'd0, 0, 0, 1, 0);
    chk("R11", "release to slow", mode_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_run_slow();
    t_idle_from_run();
    t_idle_from_slow();
    t_ignore();
    t_collision();
    t_sleep();
    t_deep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule